// File: doc/BRIEF.md
# Prescaled Modulo Up-Counter Timer

This block is a 16-bit up-counter that advances once per selected count tick and returns to zero after reaching a programmable modulo value. The count tick comes from a free-running divider on the bus clock (divide by 1 through 64 in powers of two) or from rising edges of an external clock input. The external input is synchronized into the bus clock domain, so the whole block runs on one clock.

Software reaches three registers through a simple one-cycle read/write port:

- **Control/status word** at address 0:
  - bit 7: overflow flag
  - bit 6: interrupt enable
  - bit 5: halt
  - bit 4: clear, which is write-only and always reads 0
  - bits 2:0: tick source select
- **Live count** at address 1, read-only.
- **Modulo limit** at address 2.

Reaching the limit sets the overflow flag. Software clears the flag with a read of the control word followed by a write of 0 to bit 7. An overflow that lands between that read and that write cancels the clear. The interrupt output follows the flag, gated by the enable bit.

Top module: `modulo_timer`

## Requirements
- R1: Writing 0 to bit 7 of the control word clears the flag only if a read of the control word, made while the flag was 1, came after the most recent control write. Without such a read, the write leaves the flag at 1.
- R2: An overflow event that occurs after the arming read and before the clearing write cancels the handshake. The flag stays 1 after that write, and a new read is required.
- R3: Writing 1 to bit 7 never changes the flag.
- R4: The flag sets on the tick that moves the count onto the modulo value. The next active tick returns the count to 0.
- R5: `irq` is 1 exactly while the flag and the enable bit (bit 6) are both 1.
- R6: After reset the control word reads 0x20 (halted, select 0), the count reads 0 and the modulo reads 0xFFFF.
- R7: While halt is 1 the count holds its value. It resumes counting after halt is written to 0.
- R8: A control write with bit 4 set zeroes the count and the divider on that edge. Bit 4 reads back as 0, and the modulo register is not affected.
- R9: A single control write with both halt and clear set leaves the count parked at 0.
- R10: Select codes 0 to 6 advance the count once every 2^code bus cycles, with the phase set by the divider, which restarts at the clear.
- R11: Select code 7 advances the count once per rising edge of `ext_clk`, after a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 2 | Register address: 0 control, 1 count, 2 modulo |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq | output | 1 | Overflow interrupt request |

## Verification
Some properties are checked on every cycle. These are:
- the count holding while halted;
- the step-by-one and wrap-to-zero behaviour;
- the clear command zeroing both count and divider;
- an overflow event always setting the flag;
- a write of 1, or an unarmed write, never dropping the flag;
- the synchronized external edge lasting one cycle.

Only the bench scenarios can show the rest:
- the order-dependent handshake, that is, read then write, with an overflow squeezed between them;
- the exact tick rate of each select code;
- the counted number of external edges;
- parking at zero when halt and clear are written together.

// File: rtl/timer_pkg.sv
package timer_pkg;
   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_COUNT = 2'd1,
      REG_MOD   = 2'd2
   } reg_sel_e;

   localparam int FLAG_BIT = 7;
   localparam int IE_BIT   = 6;
   localparam int HALT_BIT = 5;
   localparam int CLR_BIT  = 4;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   input  logic             ext_in,
   output logic             tick
);
   localparam int DIV_TAPS = (1 << SEL_W) - 1;
   localparam int PRE_W    = DIV_TAPS - 1;

   if (SEL_W < 2 || SEL_W > 4) begin : g_bad_sel
      $error("tick_gen: SEL_W must lie in 2..4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tick_gen: SYNC_STAGES must be at least 2");
   end

   logic [PRE_W-1:0]     pre_q;
   logic [SYNC_STAGES:0] sh_q;
   logic                 ext_edge;
   logic [DIV_TAPS:0]    taps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_in};
   end

   assign ext_edge = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

   genvar g;
   for (g = 0; g < DIV_TAPS; g++) begin : g_tap
      if (g == 0) begin : g_div1
         assign taps[g] = 1'b1;
      end else begin : g_divn
         assign taps[g] = &pre_q[g-1:0];
      end
   end
   assign taps[DIV_TAPS] = ext_edge;

   assign tick = ~clr & taps[sel];

   AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre_q == '0)); // R8
   AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_edge |=> !ext_edge); // R11
endmodule

// File: rtl/count_core.sv
module count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             halt,
   input  logic             clr,
   input  logic [CNT_W-1:0] modulo,
   output logic [CNT_W-1:0] count,
   output logic             hit
);
   logic             advance;
   logic             at_mod;
   logic [CNT_W-1:0] nxt;

   assign advance = tick & ~halt & ~clr;
   assign at_mod  = (count == modulo);
   assign nxt     = at_mod ? '0 : count + 1'b1;
   assign hit     = advance && (nxt == modulo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (clr)     count <= '0;
      else if (advance) count <= nxt;
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R8
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !clr) |=> (count == $past(count))); // R7
   AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && at_mod) |=> (count == '0)); // R4
   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !at_mod) |=> (count == $past(count) + 1'b1)); // R10
endmodule

// File: rtl/ovf_flag.sv
module ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic rd_ctrl,
   input  logic wr_ctrl,
   input  logic wr_flag_bit,
   output logic flag
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else if (hit) begin
         flag  <= 1'b1;
         armed <= 1'b0;
      end else if (wr_ctrl) begin
         if (armed && !wr_flag_bit) flag <= 1'b0;
         armed <= 1'b0;
      end else if (rd_ctrl && flag) begin
         armed <= 1'b1;
      end
   end

   AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag); // R4
   AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && wr_ctrl && wr_flag_bit) |=> flag); // R3
   AST_UNARMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !armed && wr_ctrl) |=> flag); // R1
   AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !hit) |=> !flag); // R4
endmodule

// File: rtl/modulo_timer.sv
module modulo_timer
   import timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   input  logic             ext_clk,
   output logic             irq
);
   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_width
      $error("modulo_timer: CNT_W must lie in 8..32");
   end
   if (SEL_W > CLR_BIT) begin : g_bad_sel
      $error("modulo_timer: SEL_W overlaps the control bits");
   end

   logic             ie_q;
   logic             halt_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] count;
   logic             wr_ctrl;
   logic             rd_ctrl;
   logic             clr_cmd;
   logic             tick;
   logic             hit;
   logic             flag;

   assign wr_ctrl = wr_en && (addr == REG_CTRL);
   assign rd_ctrl = rd_en && (addr == REG_CTRL);
   assign clr_cmd = wr_ctrl && wdata[CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         halt_q <= 1'b1;
         sel_q  <= '0;
         mod_q  <= '1;
      end else if (wr_en) begin
         if (addr == REG_CTRL) begin
            ie_q   <= wdata[IE_BIT];
            halt_q <= wdata[HALT_BIT];
            sel_q  <= wdata[SEL_W-1:0];
         end else if (addr == REG_MOD) begin
            mod_q  <= wdata;
         end
      end
   end

   tick_gen #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_cmd),
      .sel   (sel_q),
      .ext_in(ext_clk),
      .tick  (tick)
   );

   count_core #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .halt  (halt_q),
      .clr   (clr_cmd),
      .modulo(mod_q),
      .count (count),
      .hit   (hit)
   );

   ovf_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit),
      .rd_ctrl    (rd_ctrl),
      .wr_ctrl    (wr_ctrl),
      .wr_flag_bit(wdata[FLAG_BIT]),
      .flag       (flag)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CTRL: begin
            rdata[FLAG_BIT]  = flag;
            rdata[IE_BIT]    = ie_q;
            rdata[HALT_BIT]  = halt_q;
            rdata[SEL_W-1:0] = sel_q;
         end
         REG_COUNT: rdata = count;
         REG_MOD:   rdata = mod_q;
         default:   rdata = '0;
      endcase
   end

   assign irq = flag & ie_q;

   AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd && wdata[HALT_BIT]) |=> (count == '0)); // R9
   AST_CLR_KEEPS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd) |=> (mod_q == $past(mod_q))); // R8
endmodule

// File: tb/tb_modulo_timer.sv
`timescale 1ns/1ps
module tb_modulo_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        ext_clk = 1'b0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   modulo_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .irq(irq)
   );

   // Behavioural reference state
   int m_cnt, m_mod, m_pre, m_sel;
   bit m_flag, m_armed, m_ie, m_halt;
   bit m_sync[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int m_read(input int a);
      if (a == 0) return (int'(m_flag) << 7) | (int'(m_ie) << 6) | (int'(m_halt) << 5) | m_sel;
      if (a == 1) return m_cnt;
      if (a == 2) return m_mod;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_mod = 16'hFFFF; m_pre = 0; m_sel = 0;
         m_flag = 0; m_armed = 0; m_ie = 0; m_halt = 1;
         m_sync = '{0, 0, 0};
      end else begin
         bit clr, t, adv, hit, e;
         int nx, div;
         clr = wr_en && addr == 0 && wdata[4];
         e = m_sync[1] && !m_sync[2];
         div = 1 << m_sel;
         t = (m_sel == 7) ? e : ((m_pre % div) == div - 1);
         if (clr) t = 0;
         adv = t && !m_halt && !clr;
         nx = (m_cnt == m_mod) ? 0 : m_cnt + 1;
         hit = adv && nx == m_mod;
         if (hit) begin m_flag = 1; m_armed = 0; end
         else if (wr_en && addr == 0) begin
            if (m_armed && !wdata[7]) m_flag = 0;
            m_armed = 0;
         end else if (rd_en && addr == 0 && m_flag) m_armed = 1;
         if (clr) m_cnt = 0; else if (adv) m_cnt = nx;
         m_pre = clr ? 0 : (m_pre + 1) % 64;
         m_sync.push_front(ext_clk);
         void'(m_sync.pop_back());
         if (wr_en && addr == 0) begin
            m_ie = wdata[6]; m_halt = wdata[5]; m_sel = int'(wdata[2:0]);
         end else if (wr_en && addr == 2) m_mod = int'(wdata);
      end
   end

   // Per-cycle comparison after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(rdata == 16'(m_read(int'(addr))), "model rdata", int'(rdata), m_read(int'(addr)));
         chk(irq == (m_flag && m_ie), "model irq R5", int'(irq), int'(m_flag && m_ie));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); wr_en = 1; addr = 2'(a); wdata = 16'(d);
      @(negedge clk); wr_en = 0; addr = 2'd1; wdata = 16'd0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk); rd_en = 1; addr = 2'(a);
      #1 v = int'(rdata);
      @(negedge clk); rd_en = 0; addr = 2'd1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int v, a;
      addr = 2'd1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R6 reset state
      rd(0, v); chk(v == 'h20, "R6 ctrl", v, 'h20);
      rd(1, v); chk(v == 0, "R6 count", v, 0);
      rd(2, v); chk(v == 'hFFFF, "R6 modulo", v, 'hFFFF);
      // R7 halt holds, resume counts
      wr(0, 'h00); idle(30); wr(0, 'h20);
      rd(1, a); chk(a == m_cnt && a != 0, "R7 halted count", a, m_cnt);
      idle(20);
      rd(1, v); chk(v == a, "R7 hold", v, a);
      wr(0, 'h00); idle(5); wr(0, 'h20);
      rd(1, v); chk(v != a && v == m_cnt, "R7 resume", v, m_cnt);
      // R9 halt+clear parks at zero
      wr(0, 'h30); idle(5);
      rd(1, v); chk(v == 0, "R9 parked", v, 0);
      rd(0, v); chk(v == 'h20, "R8 clear bit reads 0", v, 'h20);
      // R10 divided ticks
      for (int s = 1; s < 7; s += 2) begin
         wr(0, 'h30 | s); wr(0, s); idle(150); wr(0, 'h20 | s);
         rd(1, v); chk(v == m_cnt && v > 0, "R10 divided count", v, m_cnt);
      end
      // R4 modulo wrap and flag
      wr(2, 4); wr(0, 'h50); wr(0, 'h40); idle(12);
      chk(irq == 1, "R5 irq with flag and enable", int'(irq), 1);
      rd(0, v); chk(v[7] == 1, "R4 flag set", v, 'hC0);
      rd(1, v); chk(v <= 4, "R4 count within modulo", v, 4);
      // R2 intervening overflow cancels
      rd(0, v); idle(10); wr(0, 'h60);
      rd(0, v); chk(v == 'hE0, "R2 cancelled clear", v, 'hE0);
      // R3 write 1 has no effect (this read armed)
      wr(0, 'hE0);
      rd(0, v); chk(v == 'hE0, "R3 write one", v, 'hE0);
      wr(0, 'h60); // armed by previous read -> clears
      rd(0, v); chk(v == 'h60, "R1 handshake clears", v, 'h60);
      chk(irq == 0, "R5 irq low after clear", int'(irq), 0);
      // R1 unarmed write ignored: get flag again, halt, then write 0 without read
      wr(0, 'h40); idle(12); wr(0, 'h60); wr(0, 'h60);
      rd(0, v); chk(v == 'hE0, "R1 unarmed write ignored", v, 'hE0);
      wr(0, 'h20); idle(2);
      chk(irq == 0, "R5 irq masked by enable", int'(irq), 0);
      // R8 clear while running keeps modulo
      wr(0, 'h10); idle(2);
      rd(2, v); chk(v == 4, "R8 modulo kept", v, 4);
      // R11 external clock edges
      wr(2, 'hFFFF); wr(0, 'h37); wr(0, 'h07);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); ext_clk = 1; idle(3);
         ext_clk = 0; idle(3);
      end
      idle(6); wr(0, 'h27);
      rd(1, v); chk(v == 5, "R11 external edges", v, 5);
      idle(2);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule